// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block controls a bank of up to sixteen bidirectional pads from a small register bus. Each pad is either owned by software as a general-purpose line or handed to a neighbouring peripheral by a per-pin function-select bit. For software-owned pins, a direction bit enables the output driver, an output latch supplies the driven level, and an input-enable bit opens the pad receiver. The receiver feeds a two-flop synchronizer before the value reaches the read path or the peripheral.

Software can change the output latch in four ways. A whole-word load writes every pin. Three masked registers raise, lower or invert only the pins whose write-data bit is 1. Software can therefore change any mix of pins in a single bus write without a read-modify-write sequence. Reads are combinational. The bus returns data only while the read strobe is high and drives zero otherwise.

The design has no sequencing states. It is built from a register file, an input synchronizer, a pad multiplexer and a read multiplexer.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin is a general-purpose pin (function select 0), no output driver is enabled (`pad_oe` = 0), every input is disabled, the output latch is 0, and reads of the direction, input-enable and function-select registers return 0.
- R2: For a general-purpose pin, `pad_oe` equals its direction bit (1 = output) and `pad_out` equals its output latch bit. The direction register (address 4) changes only on a write to address 4.
- R3: A write to address 2 sets the latch bit of every pin whose write-data bit is 1. All other latch bits keep their value.
- R4: A write to address 1 clears the latch bit of every pin whose write-data bit is 1. All other latch bits keep their value.
- R5: A write to address 3 inverts the latch bit of every pin whose write-data bit is 1. A write-data value of 0 leaves the latch unchanged.
- R6: A write to address 0 loads the whole latch. A read of address 0 returns the latch bit for pins whose direction bit is 1, and the synchronized input for pins whose direction bit is 0.
- R7: The input-enable register (address 5) gates each pad input ahead of the synchronizer. A disabled pin reads as 0 and presents 0 on `periph_in`.
- R8: A pad level present at a rising clock edge passes through two flip-flops. It is visible on reads after the second following rising edge, and not after the first.
- R9: When a pin's function-select bit (address 6) is 1, `pad_oe` and `pad_out` for that pin follow `periph_oe` and `periph_out`. The pin's direction and latch bits have no effect on the pad.
- R10: Reads of addresses 1, 2 and 3 return the output latch. Address 7 reads as 0, and a write to it changes no register.
- R11: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NUM_PINS | Write data, one bit per pin |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NUM_PINS | Combinational read data |
| pad_in | input | NUM_PINS | Level seen at each pad |
| pad_out | output | NUM_PINS | Level driven toward each pad |
| pad_oe | output | NUM_PINS | Output driver enable per pad |
| periph_out | input | NUM_PINS | Peripheral output level per pin |
| periph_oe | input | NUM_PINS | Peripheral driver enable per pin |
| periph_in | output | NUM_PINS | Synchronized, gated pad input to the peripheral |

## Verification
Every cycle, the assertions check the masked updates: set, clear and toggle each touch only the selected bits. They also check that the direction register and the unmapped address stay untouched by unrelated writes, that a pin held disabled keeps a quiet synchronizer output, and that idle read data is zero. Other behaviour can only be shown by the bench's scenarios. These include the reset values seen at the ports, the mixed output/input read word, the exact two-edge input latency, and the peripheral takeover of a pin while software keeps toggling its latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_ADDR_W = 3;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_CLR  = 3'd1,
        REG_SET  = 3'd2,
        REG_TGL  = 3'd3,
        REG_DIR  = 3'd4,
        REG_INEN = 3'd5,
        REG_FSEL = 3'd6,
        REG_NONE = 3'd7
    } gpio_reg_e;

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [GPIO_ADDR_W-1:0] addr,
    input  logic [NUM_PINS-1:0]    wdata,
    input  logic                   wr,
    output logic [NUM_PINS-1:0]    out_q,
    output logic [NUM_PINS-1:0]    dir_q,
    output logic [NUM_PINS-1:0]    inen_q,
    output logic [NUM_PINS-1:0]    fsel_q
);

    gpio_reg_e             sel;
    logic [NUM_PINS-1:0]   out_d, dir_d, inen_d, fsel_d;

    assign sel = gpio_reg_e'(addr);

    always_comb begin
        out_d  = out_q;
        dir_d  = dir_q;
        inen_d = inen_q;
        fsel_d = fsel_q;
        if (wr) begin
            unique case (sel)
                REG_DATA: out_d  = wdata;
                REG_CLR:  out_d  = out_q & ~wdata;
                REG_SET:  out_d  = out_q | wdata;
                REG_TGL:  out_d  = out_q ^ wdata;
                REG_DIR:  dir_d  = wdata;
                REG_INEN: inen_d = wdata;
                REG_FSEL: fsel_d = wdata;
                REG_NONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            inen_q <= '0;
            fsel_q <= '0;
        end else begin
            out_q  <= out_d;
            dir_q  <= dir_d;
            inen_q <= inen_d;
            fsel_q <= fsel_d;
        end
    end

    AST_SET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == REG_SET) |=> ((out_q & $past(wdata)) == $past(wdata)) &&
                                    ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))); // R3
    AST_CLR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == REG_CLR) |=> ((out_q & $past(wdata)) == '0) &&
                                    ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))); // R4
    AST_TGL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == REG_TGL) |=> (out_q ^ $past(out_q)) == $past(wdata)); // R5
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == REG_DIR) |=> $stable(dir_q)); // R2
    AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == REG_NONE) |=> $stable(out_q) && $stable(dir_q) &&
                                     $stable(inen_q) && $stable(fsel_q)); // R10

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] inen,
    output logic [NUM_PINS-1:0] sync_out
);

    localparam int LAST = SYNC_STAGES - 1;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [LAST:0] chain;
        logic          gated;

        assign gated = pad_in[p] & inen[p];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[LAST-1:0], gated};
        end

        assign sync_out[p] = chain[LAST];

        if (SYNC_STAGES == 2) begin : g_chk
            AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (!inen[p] && !$past(inen[p])) |=> !sync_out[p]); // R7
        end
    end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NUM_PINS = 16
) (
    input  logic [NUM_PINS-1:0] fsel,
    input  logic [NUM_PINS-1:0] gpio_out,
    input  logic [NUM_PINS-1:0] gpio_dir,
    input  logic [NUM_PINS-1:0] periph_out,
    input  logic [NUM_PINS-1:0] periph_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            if (fsel[p]) begin
                pad_out[p] = periph_out[p];
                pad_oe[p]  = periph_oe[p];
            end else begin
                pad_out[p] = gpio_out[p];
                pad_oe[p]  = gpio_dir[p];
            end
        end
    end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd,
    input  logic [GPIO_ADDR_W-1:0] addr,
    input  logic [NUM_PINS-1:0]    out_q,
    input  logic [NUM_PINS-1:0]    dir_q,
    input  logic [NUM_PINS-1:0]    inen_q,
    input  logic [NUM_PINS-1:0]    fsel_q,
    input  logic [NUM_PINS-1:0]    sync_in,
    output logic [NUM_PINS-1:0]    rdata
);

    logic [NUM_PINS-1:0] word;

    always_comb begin
        unique case (gpio_reg_e'(addr))
            REG_DATA: word = (out_q & dir_q) | (sync_in & ~dir_q);
            REG_CLR,
            REG_SET,
            REG_TGL:  word = out_q;
            REG_DIR:  word = dir_q;
            REG_INEN: word = inen_q;
            REG_FSEL: word = fsel_q;
            REG_NONE: word = '0;
        endcase
    end

    assign rdata = rd ? word : '0;

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> rdata == '0); // R11

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic [NUM_PINS-1:0]    bus_wdata,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    output logic [NUM_PINS-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0]    pad_in,
    output logic [NUM_PINS-1:0]    pad_out,
    output logic [NUM_PINS-1:0]    pad_oe,
    input  logic [NUM_PINS-1:0]    periph_out,
    input  logic [NUM_PINS-1:0]    periph_oe,
    output logic [NUM_PINS-1:0]    periph_in
);

    logic [NUM_PINS-1:0] out_q, dir_q, inen_q, fsel_q, sync_q;

    gpio_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .wr     (bus_wr),
        .out_q  (out_q),
        .dir_q  (dir_q),
        .inen_q (inen_q),
        .fsel_q (fsel_q)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .inen     (inen_q),
        .sync_out (sync_q)
    );

    gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_pads (
        .fsel       (fsel_q),
        .gpio_out   (out_q),
        .gpio_dir   (dir_q),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    gpio_rd_mux #(.NUM_PINS(NUM_PINS)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .inen_q  (inen_q),
        .fsel_q  (fsel_q),
        .sync_in (sync_q),
        .rdata   (bus_rdata)
    );

    assign periph_in = sync_q;

    AST_RESET_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pad_oe == (fsel_q & periph_oe)); // R1

endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe;
    logic [N-1:0] periph_out = '0;
    logic [N-1:0] periph_oe = '0;
    logic [N-1:0] periph_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];

    always #5 clk = ~clk;

    gpio_port_ctrl #(.NUM_PINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .periph_out(periph_out),
        .periph_oe(periph_oe), .periph_in(periph_in)
    );

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a read strobe is seen
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) check("READ-UNEXPECTED", bus_rdata, 'x);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end else if (rst_n) begin
            check("R11 idle rdata", bus_rdata, '0);
        end
    end

    task automatic bus_write(logic [2:0] a, logic [N-1:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [2:0] a, logic [N-1:0] exp, string tag);
        @(posedge clk); #1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        pad_in = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 pad_oe after reset", pad_oe, '0);
        check("R1 periph_in after reset", periph_in, '0);
        bus_read(3'd0, 16'h0000, "R1 R7 data read, inputs disabled");
        bus_read(3'd2, 16'h0000, "R1 latch after reset");
        bus_read(3'd4, 16'h0000, "R1 direction after reset");
        bus_read(3'd5, 16'h0000, "R1 input enable after reset");
        bus_read(3'd6, 16'h0000, "R1 function select after reset");
        pad_in = '0;

        bus_write(3'd4, 16'h00FF);
        #2 check("R2 pad_oe follows direction", pad_oe, 16'h00FF);
        bus_read(3'd4, 16'h00FF, "R2 direction readback");

        bus_write(3'd0, 16'hA5A5);
        bus_read(3'd0, 16'h00A5, "R6 mixed data read");
        bus_write(3'd2, 16'h0F00);
        bus_read(3'd2, 16'hAFA5, "R3 R10 set, read at set address");
        bus_write(3'd1, 16'h0005);
        bus_read(3'd1, 16'hAFA0, "R4 R10 clear, read at clear address");
        bus_write(3'd3, 16'hFFFF);
        bus_read(3'd3, 16'h505F, "R5 R10 toggle, read at toggle address");
        bus_write(3'd3, 16'h0000);
        bus_read(3'd3, 16'h505F, "R5 zero toggle mask");
        #2 check("R2 pad_out follows latch", pad_out, 16'h505F);

        bus_write(3'd5, 16'hFF00);
        repeat (3) @(posedge clk);
        #1 pad_in = 16'h1234;
        bus_read(3'd0, 16'h005F, "R8 input not visible after one edge");
        bus_read(3'd0, 16'h125F, "R8 R6 input visible after two edges");
        #2 check("R7 periph_in with enabled inputs", periph_in, 16'h1200);

        bus_write(3'd5, 16'h0F00);
        repeat (3) @(posedge clk);
        bus_read(3'd0, 16'h025F, "R7 disabled inputs read zero");
        #2 check("R7 periph_in gated", periph_in, 16'h0200);

        periph_out = 16'hFFFF;
        periph_oe  = 16'h8000;
        bus_write(3'd6, 16'h8001);
        #2 check("R9 pad_oe under peripheral", pad_oe, 16'h80FE);
        check("R9 pad_out under peripheral", pad_out, 16'hD05F);
        bus_read(3'd6, 16'h8001, "R9 function select readback");
        bus_write(3'd3, 16'hFFFF);
        #2 check("R9 latch toggle ignored on peripheral pins", pad_out, 16'hAFA1);

        bus_write(3'd7, 16'hFFFF);
        bus_read(3'd7, 16'h0000, "R10 unmapped address reads zero");
        bus_read(3'd0, 16'h02A0, "R10 unmapped write ignored");
        bus_read(3'd4, 16'h00FF, "R10 R2 direction kept");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule